// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block sits next to a small CPU core and carries out entry into an exception or interrupt handler. When the core reports an event (a fault, a trap or an external interrupt), or when a single-step trap comes due after an instruction retires, the sequencer latches the machine state it was given. It picks which return address to save from the event class. If the core was running in user mode, it moves onto the kernel stack named by two task-state inputs. It then writes the entry frame to memory, one 32-bit word per cycle, with the stack pointer stepping down by four before each write.

Once the frame is written, the sequencer issues a single read of the 64-bit gate for the vector from a descriptor table. The table is located by a 48-bit table register. The sequencer then hands the new code selector, the entry point, the gate attribute half-word and the final stack segment and pointer back to the core with a one-cycle done pulse. A vector whose gate would fall outside the table limit raises an error pulse, and the sequencer writes nothing and reads nothing.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, busy_o, mw_valid_o, dr_valid_o, done_o and limit_err_o are all 0.
- R2: For a fault (evt_class_i = 2'b00), the return-address word in the frame is cur_ip_i, the address of the faulting instruction.
- R3: For a trap (evt_class_i = 2'b01) or an interrupt (evt_class_i = 2'b10), the return-address word in the frame is next_ip_i.
- R4: With user_mode_i = 1, the block first switches to tss_ss_i and tss_sp_i. It then writes five words on consecutive cycles: the old stack segment (zero-extended), the old stack pointer, the flags, the old code selector (zero-extended) and the return address. The addresses are tss_sp_i-4, -8, -12, -16 and -20, and mw_seg_o equals tss_ss_i on each write.
- R5: With user_mode_i = 0, the block writes three words on consecutive cycles (flags, old code selector, return address) to cur_sp_i-4, -8 and -12, with mw_seg_o equal to cur_ss_i.
- R6: After the last write, exactly one descriptor read is issued, at address idt_reg_i[47:16] + 8*vector.
- R7: When the read data returns, done_o pulses for one cycle. At that pulse, new_cs_o is data bits 31..16, new_ip_o is {data bits 63..48, data bits 15..0}, gate_attr_o is data bits 47..32, and new_ss_o/new_sp_o hold the stack segment and the pointer after the last write.
- R8: If 8*vector+7 is greater than idt_reg_i[15:0], limit_err_o pulses for one cycle and no write, read or done follows. A vector whose last gate byte equals the limit is accepted.
- R9: When retire_i and trap_flag_i are both 1 and no event is offered, the block takes a trap entry with vector 1 that saves next_ip_i.
- R10: An offered event takes priority over a due single-step trap in the same cycle, and events offered while busy_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid_i | input | 1 | Event offered this cycle |
| evt_class_i | input | 2 | 00 fault, 01 trap, 10 interrupt |
| evt_vector_i | input | 8 | Vector number of the event |
| retire_i | input | 1 | Current instruction retires this cycle |
| trap_flag_i | input | 1 | Single-step trap flag of the core |
| user_mode_i | input | 1 | Core is running in user mode |
| cur_ip_i | input | 32 | Address of the current instruction |
| next_ip_i | input | 32 | Address of the following instruction |
| cur_cs_i | input | 16 | Current code selector |
| cur_ss_i | input | 16 | Current stack segment |
| cur_sp_i | input | 32 | Current stack pointer |
| cur_flags_i | input | 32 | Current flags word |
| tss_ss_i | input | 16 | Kernel stack segment from task state |
| tss_sp_i | input | 32 | Kernel stack pointer from task state |
| idt_reg_i | input | 48 | Table base (47..16) and limit (15..0) |
| busy_o | output | 1 | Entry sequence in progress |
| mw_valid_o | output | 1 | Stack write strobe |
| mw_addr_o | output | 32 | Stack write address |
| mw_seg_o | output | 16 | Stack segment of the write |
| mw_data_o | output | 32 | Stack write data |
| dr_valid_o | output | 1 | Descriptor read request |
| dr_addr_o | output | 32 | Descriptor read address |
| dr_rvalid_i | input | 1 | Descriptor read data valid |
| dr_data_i | input | 64 | Descriptor read data |
| done_o | output | 1 | Entry complete, handler fields valid |
| new_cs_o | output | 16 | Handler code selector |
| new_ip_o | output | 32 | Handler entry point |
| gate_attr_o | output | 16 | Gate attribute half-word |
| new_ss_o | output | 16 | Stack segment after entry |
| new_sp_o | output | 32 | Stack pointer after entry |
| limit_err_o | output | 1 | Gate outside table limit |

## Verification
The entry path is exercised for faults, traps and interrupts, each entered from both user and kernel mode. The fault and trap cases show whether the current or the next address is saved. The user and kernel cases show whether the extra stack-switch pair is written and which stack is used. Vectors 0, 255 and a vector whose last gate byte lands exactly on the limit are compared with one vector that sits just past a small limit, which separates the inclusive bound from an off-by-one. Single-step entries are run alone, together with a real event in the same cycle, and with a second event offered during the pushes, to tell the priority apart from the busy lock-out.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN        = 32;
    localparam int SEL_W       = 16;
    localparam int VEC_W       = 8;
    localparam int LIM_W       = 16;
    localparam int TBL_W       = XLEN + LIM_W;
    localparam int GATE_W      = 64;
    localparam int WORD_BYTES  = 4;
    localparam int GATE_BYTES  = 8;
    localparam int GATE_SHIFT  = $clog2(GATE_BYTES);
    localparam int FRAME_MAX   = 5;
    localparam int FRAME_KERN  = 3;
    localparam int IDX_W       = $clog2(FRAME_MAX);
    localparam logic [VEC_W-1:0] STEP_VEC = VEC_W'(1);

    typedef enum logic [1:0] {
        EV_FAULT = 2'b00,
        EV_TRAP  = 2'b01,
        EV_INTR  = 2'b10
    } ev_class_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PUSH,
        S_DREQ,
        S_DWAIT
    } seq_state_e;

    // Word order on the stack: index 0 is pushed first.
    typedef struct packed {
        logic [XLEN-1:0] old_ss;
        logic [XLEN-1:0] old_sp;
        logic [XLEN-1:0] flags;
        logic [XLEN-1:0] cs;
        logic [XLEN-1:0] eip;
    } frame_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [XLEN-1:0]  entry;
        logic [15:0]      attr;
    } gate_t;

    function automatic logic [XLEN-1:0] pick_return(
        input ev_class_e       cls,
        input logic [XLEN-1:0] here,
        input logic [XLEN-1:0] after
    );
        return (cls == EV_FAULT) ? here : after;
    endfunction

    function automatic logic gate_fits(
        input logic [VEC_W-1:0] vec,
        input logic [LIM_W-1:0] lim
    );
        logic [LIM_W:0] last_byte;
        last_byte = (LIM_W+1)'({vec, {GATE_SHIFT{1'b1}}});
        return last_byte <= {1'b0, lim};
    endfunction

endpackage

// File: rtl/exc_event_sel.sv
module exc_event_sel
    import exc_entry_pkg::*;
(
    input  logic             evt_valid_i,
    input  ev_class_e        evt_class_i,
    input  logic [VEC_W-1:0] evt_vec_i,
    input  logic             retire_i,
    input  logic             trap_flag_i,
    output logic             start_o,
    output ev_class_e        cls_o,
    output logic [VEC_W-1:0] vec_o
);
    logic step_due;
    assign step_due = retire_i & trap_flag_i;
    assign start_o  = evt_valid_i | step_due;

    always_comb begin
        if (evt_valid_i) begin
            cls_o = evt_class_i;
            vec_o = evt_vec_i;
        end else begin
            cls_o = EV_TRAP;
            vec_o = STEP_VEC;
        end
    end
endmodule

// File: rtl/exc_frame_mux.sv
module exc_frame_mux
    import exc_entry_pkg::*;
(
    input  frame_t           frame_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [XLEN-1:0]  word_o
);
    always_comb begin
        case (idx_i)
            IDX_W'(0): word_o = frame_i.old_ss;
            IDX_W'(1): word_o = frame_i.old_sp;
            IDX_W'(2): word_o = frame_i.flags;
            IDX_W'(3): word_o = frame_i.cs;
            default:   word_o = frame_i.eip;
        endcase
    end
endmodule

// File: rtl/exc_gate_decode.sv
module exc_gate_decode
    import exc_entry_pkg::*;
(
    input  logic [GATE_W-1:0] desc_i,
    output gate_t             gate_o
);
    assign gate_o.sel   = desc_i[31:16];
    assign gate_o.entry = {desc_i[63:48], desc_i[15:0]};
    assign gate_o.attr  = desc_i[47:32];
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid_i,
    input  logic [1:0]        evt_class_i,
    input  logic [VEC_W-1:0]  evt_vector_i,
    input  logic              retire_i,
    input  logic              trap_flag_i,
    input  logic              user_mode_i,
    input  logic [XLEN-1:0]   cur_ip_i,
    input  logic [XLEN-1:0]   next_ip_i,
    input  logic [SEL_W-1:0]  cur_cs_i,
    input  logic [SEL_W-1:0]  cur_ss_i,
    input  logic [XLEN-1:0]   cur_sp_i,
    input  logic [XLEN-1:0]   cur_flags_i,
    input  logic [SEL_W-1:0]  tss_ss_i,
    input  logic [XLEN-1:0]   tss_sp_i,
    input  logic [TBL_W-1:0]  idt_reg_i,
    output logic              busy_o,
    output logic              mw_valid_o,
    output logic [XLEN-1:0]   mw_addr_o,
    output logic [SEL_W-1:0]  mw_seg_o,
    output logic [XLEN-1:0]   mw_data_o,
    output logic              dr_valid_o,
    output logic [XLEN-1:0]   dr_addr_o,
    input  logic              dr_rvalid_i,
    input  logic [GATE_W-1:0] dr_data_i,
    output logic              done_o,
    output logic [SEL_W-1:0]  new_cs_o,
    output logic [XLEN-1:0]   new_ip_o,
    output logic [15:0]       gate_attr_o,
    output logic [SEL_W-1:0]  new_ss_o,
    output logic [XLEN-1:0]   new_sp_o,
    output logic              limit_err_o
);
    localparam logic [IDX_W-1:0] IDX_USER = '0;
    localparam logic [IDX_W-1:0] IDX_KERN = IDX_W'(FRAME_MAX - FRAME_KERN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_MAX - 1);
    localparam logic [XLEN-1:0]  SP_STEP  = XLEN'(WORD_BYTES);

    seq_state_e       state_q;
    logic [XLEN-1:0]  sp_q;
    logic [SEL_W-1:0] ss_q;
    logic [IDX_W-1:0] idx_q;
    logic [VEC_W-1:0] vec_q;
    frame_t           frame_q;
    gate_t            gate_q;
    logic             done_q;
    logic             err_q;

    logic             start;
    ev_class_e        sel_cls;
    logic [VEC_W-1:0] sel_vec;
    logic [XLEN-1:0]  push_word;
    gate_t            gate_dec;
    logic [XLEN-1:0]  tbl_base;
    logic [LIM_W-1:0] tbl_lim;

    assign tbl_base = idt_reg_i[TBL_W-1:LIM_W];
    assign tbl_lim  = idt_reg_i[LIM_W-1:0];

    exc_event_sel u_sel (
        .evt_valid_i (evt_valid_i),
        .evt_class_i (ev_class_e'(evt_class_i)),
        .evt_vec_i   (evt_vector_i),
        .retire_i    (retire_i),
        .trap_flag_i (trap_flag_i),
        .start_o     (start),
        .cls_o       (sel_cls),
        .vec_o       (sel_vec)
    );

    exc_frame_mux u_mux (
        .frame_i (frame_q),
        .idx_i   (idx_q),
        .word_o  (push_word)
    );

    exc_gate_decode u_gate (
        .desc_i (dr_data_i),
        .gate_o (gate_dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            sp_q    <= '0;
            ss_q    <= '0;
            idx_q   <= '0;
            vec_q   <= '0;
            frame_q <= '0;
            gate_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        if (!gate_fits(sel_vec, tbl_lim)) begin
                            err_q <= 1'b1;
                        end else begin
                            vec_q          <= sel_vec;
                            frame_q.old_ss <= XLEN'(cur_ss_i);
                            frame_q.old_sp <= cur_sp_i;
                            frame_q.flags  <= cur_flags_i;
                            frame_q.cs     <= XLEN'(cur_cs_i);
                            frame_q.eip    <= pick_return(sel_cls, cur_ip_i, next_ip_i);
                            if (user_mode_i) begin
                                sp_q  <= tss_sp_i;
                                ss_q  <= tss_ss_i;
                                idx_q <= IDX_USER;
                            end else begin
                                sp_q  <= cur_sp_i;
                                ss_q  <= cur_ss_i;
                                idx_q <= IDX_KERN;
                            end
                            state_q <= S_PUSH;
                        end
                    end
                end
                S_PUSH: begin
                    sp_q <= sp_q - SP_STEP;
                    if (idx_q == IDX_LAST) begin
                        state_q <= S_DREQ;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                S_DREQ: begin
                    state_q <= S_DWAIT;
                end
                S_DWAIT: begin
                    if (dr_rvalid_i) begin
                        gate_q  <= gate_dec;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != S_IDLE);
    assign mw_valid_o  = (state_q == S_PUSH);
    assign mw_addr_o   = sp_q - SP_STEP;
    assign mw_seg_o    = ss_q;
    assign mw_data_o   = push_word;
    assign dr_valid_o  = (state_q == S_DREQ);
    assign dr_addr_o   = tbl_base + (XLEN'(vec_q) << GATE_SHIFT);
    assign done_o      = done_q;
    assign new_cs_o    = gate_q.sel;
    assign new_ip_o    = gate_q.entry;
    assign gate_attr_o = gate_q.attr;
    assign new_ss_o    = ss_q;
    assign new_sp_o    = sp_q;
    assign limit_err_o = err_q;

    // R4 / R5: consecutive pushes step the stack down one word
    a_r4_push_step: assert property (@(posedge clk) disable iff (rst)
        (mw_valid_o && $past(mw_valid_o)) |-> (mw_addr_o == $past(mw_addr_o) - SP_STEP));

    // R4 / R5: the stack segment does not change within a frame
    a_r5_seg_steady: assert property (@(posedge clk) disable iff (rst)
        (mw_valid_o && $past(mw_valid_o)) |-> $stable(mw_seg_o));

    // R6: one descriptor read per entry
    a_r6_single_read: assert property (@(posedge clk) disable iff (rst)
        dr_valid_o |=> !dr_valid_o);

    // R6: the read follows the last push
    a_r6_read_after_push: assert property (@(posedge clk) disable iff (rst)
        $fell(mw_valid_o) |-> dr_valid_o);

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: an out-of-limit vector starts nothing
    a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
        limit_err_o |-> (!busy_o && !done_o));

    // R8: after an error no write follows
    a_r8_err_no_write: assert property (@(posedge clk) disable iff (rst)
        limit_err_o |=> !mw_valid_o);

    // R10: write, read and done never overlap
    a_r10_phases: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mw_valid_o, dr_valid_o, done_o, limit_err_o}));

endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid_i = 1'b0;
    logic [1:0]  evt_class_i = 2'b00;
    logic [7:0]  evt_vector_i = 8'd0;
    logic        retire_i = 1'b0;
    logic        trap_flag_i = 1'b0;
    logic        user_mode_i = 1'b0;
    logic [31:0] cur_ip_i = '0;
    logic [31:0] next_ip_i = '0;
    logic [15:0] cur_cs_i = '0;
    logic [15:0] cur_ss_i = '0;
    logic [31:0] cur_sp_i = '0;
    logic [31:0] cur_flags_i = '0;
    logic [15:0] tss_ss_i = '0;
    logic [31:0] tss_sp_i = '0;
    logic [47:0] idt_reg_i = '0;
    logic        dr_rvalid_i = 1'b0;
    logic [63:0] dr_data_i = '0;

    logic        busy_o, mw_valid_o, dr_valid_o, done_o, limit_err_o;
    logic [31:0] mw_addr_o, mw_data_o, dr_addr_o, new_ip_o, new_sp_o;
    logic [15:0] mw_seg_o, new_cs_o, gate_attr_o, new_ss_o;

    int nchk = 0;
    int nfail = 0;

    localparam logic [31:0] TBL_BASE = 32'h0010_0000;

    always #2.5 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst(rst),
        .evt_valid_i(evt_valid_i), .evt_class_i(evt_class_i), .evt_vector_i(evt_vector_i),
        .retire_i(retire_i), .trap_flag_i(trap_flag_i), .user_mode_i(user_mode_i),
        .cur_ip_i(cur_ip_i), .next_ip_i(next_ip_i), .cur_cs_i(cur_cs_i), .cur_ss_i(cur_ss_i),
        .cur_sp_i(cur_sp_i), .cur_flags_i(cur_flags_i), .tss_ss_i(tss_ss_i), .tss_sp_i(tss_sp_i),
        .idt_reg_i(idt_reg_i), .busy_o(busy_o), .mw_valid_o(mw_valid_o), .mw_addr_o(mw_addr_o),
        .mw_seg_o(mw_seg_o), .mw_data_o(mw_data_o), .dr_valid_o(dr_valid_o), .dr_addr_o(dr_addr_o),
        .dr_rvalid_i(dr_rvalid_i), .dr_data_i(dr_data_i), .done_o(done_o), .new_cs_o(new_cs_o),
        .new_ip_o(new_ip_o), .gate_attr_o(gate_attr_o), .new_ss_o(new_ss_o), .new_sp_o(new_sp_o),
        .limit_err_o(limit_err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] gate_at(input logic [31:0] a);
        return {a[15:0] ^ 16'h1234, 16'h8E00, a[15:0] ^ 16'h0008, a[15:0] + 16'h0100};
    endfunction

    // Stimulus table: class, user mode, vector, limit, expect error
    typedef struct packed {
        logic [1:0]  cls;
        logic        user;
        logic [7:0]  vec;
        logic [15:0] lim;
        logic        err;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TABLE [NV] = '{
        '{2'b00, 1'b1, 8'd14,  16'h07FF, 1'b0},
        '{2'b01, 1'b0, 8'd3,   16'h07FF, 1'b0},
        '{2'b10, 1'b1, 8'h40,  16'h07FF, 1'b0},
        '{2'b00, 1'b0, 8'd0,   16'h07FF, 1'b0},
        '{2'b10, 1'b0, 8'd255, 16'h07FF, 1'b0},
        '{2'b01, 1'b1, 8'd31,  16'h00FF, 1'b0},
        '{2'b00, 1'b1, 8'd32,  16'h00FF, 1'b1}
    };

    // mode: 0 plain event, 1 single-step only, 2 event plus step, 3 event plus poke while busy
    task automatic run_entry(input logic [1:0] cls, input logic user, input logic [7:0] vec,
                             input logic [15:0] lim, input logic exp_err, input int mode);
        logic [31:0] wa [8];
        logic [31:0] wd [8];
        logic [15:0] ws [8];
        logic [31:0] ew [5];
        logic [31:0] start_sp, ra, ncs_ip;
        logic [15:0] start_ss, ncs;
        logic [63:0] g;
        logic [1:0]  ecls;
        logic [7:0]  evec;
        int nw = 0, nrd = 0, nerr = 0, ndone = 0, nexp, first;
        bit pend = 0;
        string rq_ret, rq_stk;
        ncs = '0; ncs_ip = '0; ra = '0;

        ecls = (mode == 1) ? 2'b01 : cls;
        evec = (mode == 1) ? 8'd1 : vec;

        @(negedge clk);
        idt_reg_i   = {TBL_BASE, lim};
        user_mode_i = user;
        cur_ip_i    = 32'h1000_0000 + {24'd0, evec};
        next_ip_i   = cur_ip_i + 32'd3;
        cur_cs_i    = 16'h0023;
        cur_ss_i    = 16'h002B;
        cur_sp_i    = 32'h0000_8000 + ({24'd0, evec} << 4);
        cur_flags_i = 32'h0000_0202 | ({24'd0, evec} << 12);
        tss_ss_i    = 16'h0010;
        tss_sp_i    = 32'h0004_0000;
        evt_class_i  = cls;
        evt_vector_i = vec;
        evt_valid_i  = (mode != 1);
        retire_i     = (mode == 1 || mode == 2);
        trap_flag_i  = (mode == 1 || mode == 2);
        @(negedge clk);
        evt_valid_i = 1'b0;
        retire_i    = 1'b0;
        trap_flag_i = 1'b0;

        for (int c = 0; c < 30; c++) begin
            if (pend) begin
                dr_rvalid_i = 1'b1;
                dr_data_i   = gate_at(ra);
                pend = 0;
            end else begin
                dr_rvalid_i = 1'b0;
            end
            if (mode == 3 && c == 1) begin
                evt_valid_i  = 1'b1;
                evt_vector_i = 8'h77;
                evt_class_i  = 2'b00;
            end else begin
                evt_valid_i = 1'b0;
            end
            if (mw_valid_o && nw < 8) begin
                wa[nw] = mw_addr_o; wd[nw] = mw_data_o; ws[nw] = mw_seg_o;
                nw++;
            end
            if (dr_valid_o) begin
                ra = dr_addr_o; nrd++; pend = 1;
            end
            if (limit_err_o) nerr++;
            if (done_o) begin
                ndone++;
                ncs = new_cs_o; ncs_ip = new_ip_o;
                chk(gate_attr_o == 16'h8E00, "R7", "gate attribute", {48'd0, gate_attr_o}, 64'h8E00);
                chk(new_ss_o == (user ? tss_ss_i : cur_ss_i), "R7", "new stack segment",
                    {48'd0, new_ss_o}, {48'd0, (user ? tss_ss_i : cur_ss_i)});
                chk(new_sp_o == (user ? tss_sp_i - 32'd20 : cur_sp_i - 32'd12), "R7", "new stack pointer",
                    {32'd0, new_sp_o}, {32'd0, (user ? tss_sp_i - 32'd20 : cur_sp_i - 32'd12)});
            end
            @(negedge clk);
        end
        dr_rvalid_i = 1'b0;
        evt_valid_i = 1'b0;

        if (exp_err) begin
            chk(nerr == 1, "R8", "error pulses", 64'(nerr), 64'd1);
            chk(nw == 0, "R8", "writes after error", 64'(nw), 64'd0);
            chk(nrd == 0 && ndone == 0, "R8", "read or done after error", 64'(nrd + ndone), 64'd0);
            return;
        end

        rq_ret = (mode == 1) ? "R9" : (ecls == 2'b00 ? "R2" : "R3");
        rq_stk = user ? "R4" : "R5";
        start_sp = user ? tss_sp_i : cur_sp_i;
        start_ss = user ? tss_ss_i : cur_ss_i;
        ew[0] = {16'd0, cur_ss_i};
        ew[1] = cur_sp_i;
        ew[2] = cur_flags_i;
        ew[3] = {16'd0, cur_cs_i};
        ew[4] = (ecls == 2'b00) ? cur_ip_i : next_ip_i;
        nexp  = user ? 5 : 3;
        first = user ? 0 : 2;

        chk(nerr == 0, "R8", "no error in limit", 64'(nerr), 64'd0);
        chk(nw == nexp, (mode == 3) ? "R10" : rq_stk, "push count", 64'(nw), 64'(nexp));
        if (nw == nexp) begin
            for (int k = 0; k < nexp; k++) begin
                chk(wa[k] == start_sp - 32'(4 * (k + 1)), rq_stk, "push address",
                    {32'd0, wa[k]}, {32'd0, start_sp - 32'(4 * (k + 1))});
                chk(ws[k] == start_ss, rq_stk, "push segment", {48'd0, ws[k]}, {48'd0, start_ss});
                chk(wd[k] == ew[first + k], (k == nexp - 1) ? rq_ret : rq_stk, "push data",
                    {32'd0, wd[k]}, {32'd0, ew[first + k]});
            end
        end
        chk(nrd == 1, "R6", "read count", 64'(nrd), 64'd1);
        chk(ra == TBL_BASE + ({24'd0, evec} << 3), (mode >= 2) ? "R10" : "R6", "read address",
            {32'd0, ra}, {32'd0, TBL_BASE + ({24'd0, evec} << 3)});
        chk(ndone == 1, "R7", "done pulses", 64'(ndone), 64'd1);
        g = gate_at(TBL_BASE + ({24'd0, evec} << 3));
        chk(ncs == g[31:16], "R7", "new code selector", {48'd0, ncs}, {48'd0, g[31:16]});
        chk(ncs_ip == {g[63:48], g[15:0]}, "R7", "new entry point",
            {32'd0, ncs_ip}, {32'd0, g[63:48], g[15:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog: actual 100000 cycles expected completion earlier");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy_o, mw_valid_o, dr_valid_o, done_o, limit_err_o} == 5'b0, "R1", "outputs in reset",
            {59'd0, busy_o, mw_valid_o, dr_valid_o, done_o, limit_err_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy_o, mw_valid_o, dr_valid_o, done_o, limit_err_o} == 5'b0, "R1", "outputs after reset",
            {59'd0, busy_o, mw_valid_o, dr_valid_o, done_o, limit_err_o}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_entry(TABLE[i].cls, TABLE[i].user, TABLE[i].vec, TABLE[i].lim, TABLE[i].err, 0);
        end

        // R9: single-step entry alone, kernel and user
        run_entry(2'b00, 1'b0, 8'd0, 16'h07FF, 1'b0, 1);
        run_entry(2'b00, 1'b1, 8'd0, 16'h07FF, 1'b0, 1);
        // R10: event wins over step in the same cycle
        run_entry(2'b10, 1'b0, 8'h21, 16'h07FF, 1'b0, 2);
        // R10: event offered while busy is ignored
        run_entry(2'b01, 1'b0, 8'h05, 16'h07FF, 1'b0, 3);
        // R8: limit check also guards the single-step vector
        run_entry(2'b00, 1'b0, 8'd0, 16'h000E, 1'b1, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule